// File: doc/BRIEF.md
# CAN Frame Receive Bit Checker

This block follows a CAN 2.0B bus one bit at a time on the receive side. The bit-timing logic delivers one sampled NRZ level per bit time, together with a single-cycle strobe. The checker removes stuff bits and follows the frame fields for both the 11-bit and 29-bit identifier layouts. It runs the 15-bit CRC over the frame and checks the fixed-form tail bits.

Each frame ends in one of two results. A frame that is accepted gives a one-cycle completion pulse, with the identifier, format flags, DLC and data bytes held on the outputs. A frame that is rejected gives a one-cycle error pulse with a code for the error type. After an error the checker waits for the bus to go idle before it accepts a new frame.

The block is meant to sit between a bit-sampling stage and a receive buffer, and its completion pulse can drive an interrupt directly. Bus level 0 is dominant and bus level 1 is recessive.

Top module: `can_rx_frame_checker`

## Requirements
- R1: After reset, and after any error, a start-of-frame (a dominant bit) is accepted only after 11 consecutive recessive bits; a dominant bit in that wait restarts the count. After an accepted frame, 3 recessive bits following the last end-of-frame bit are enough to accept the next start-of-frame.
- R2: From start-of-frame through the CRC sequence, the bit that follows five consecutive equal bus levels is a stuff bit and is discarded from the field data. This includes a stuff bit that falls directly after the last CRC bit. Stuff bits are themselves counted in the run of equal levels.
- R3: A stuff slot whose level equals the five bits before it gives an error pulse with code 1 at that bit.
- R4: The bit after the 11-bit base identifier and the following bit select the layout: IDE=0 is standard (RTR, IDE, r0, DLC) and IDE=1 is extended (SRR, IDE, 18 more identifier bits, RTR, r1, r0, DLC). The identifier output carries a standard identifier in bits [10:0] with the upper bits zero. It carries an extended identifier as {base, extension} in bits [28:0]. In both cases the first received bit is the most significant. The extended flag reports IDE.
- R5: The number of data bytes is the DLC, limited to 8, and is 0 when RTR is 1. Data byte k appears on bits [8k+7:8k], with its first received bit as bit 8k+7. Bytes that were not received read zero. The DLC output carries the raw 4-bit code.
- R6: The CRC uses the generator 0x4599 with a zero start value. It covers the destuffed bits from start-of-frame through the last data bit. A received CRC that differs from the computed CRC gives error code 3 at the last CRC bit.
- R7: A dominant level on the CRC delimiter, on the ACK delimiter or on any of the 7 end-of-frame bits gives error code 2 at that bit.
- R8: A recessive level in the ACK slot gives error code 4.
- R9: A frame with no error gives a one-cycle completion pulse at the clock edge that samples the strobe of its last end-of-frame bit. The frame fields are valid during that pulse.
- R10: Every error gives a one-cycle error pulse at the clock edge that samples the offending strobe, and ends the frame without a completion pulse.
- R11: The error code reads 0 whenever no error pulse is present, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle pulse marking a sampled bus bit |
| bus_bit | input | 1 | Sampled bus level (0 = dominant) |
| frame_done | output | 1 | One-cycle pulse when a valid frame completes |
| frame_id | output | 29 | Received identifier |
| frame_ext | output | 1 | 1 when the frame used the extended layout |
| frame_rtr | output | 1 | Remote request flag of the frame |
| frame_dlc | output | 4 | Raw data length code |
| frame_data | output | 64 | Data bytes, byte k on bits [8k+7:8k] |
| frame_err | output | 1 | One-cycle pulse when the frame is rejected |
| frame_err_code | output | 3 | 1 stuff, 2 form, 3 CRC, 4 acknowledge |

## Verification
Most internal faults show up within the same frame. A wrong field counter or a wrong layout decision moves every later field. The CRC window or the tail positions then shift, so the frame ends with a CRC or form error instead of the completion pulse, or the pulse comes at the wrong bit index. A faulty destuffer either drops a real bit or keeps a stuff bit, and that corrupts the CRC check at the end of the same frame. A faulty idle counter is the slow case. It shows only at the next start-of-frame, where a frame is lost after too short a gap, or a frame sent before the bus was idle is accepted anyway. For this reason the bench checks the exact bit index of every result and includes runs that are one bit short of the idle condition.

// File: rtl/can_chk_pkg.sv
package can_chk_pkg;

  localparam int CRC_W = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_STUFF = 3'd1,
    ERR_FORM  = 3'd2,
    ERR_CRC   = 3'd3,
    ERR_ACK   = 3'd4
  } rx_err_e;

  typedef enum logic [3:0] {
    FS_WAIT_IDLE,
    FS_IDLE,
    FS_BASE_ID,
    FS_BIT12,
    FS_IDE,
    FS_EXT_ID,
    FS_EXT_RTR,
    FS_RES1,
    FS_RES0,
    FS_DLC,
    FS_DATA,
    FS_CRC,
    FS_CRC_DELIM,
    FS_ACK_SLOT,
    FS_ACK_DELIM,
    FS_EOF
  } fld_state_e;

  // One serial step of the CRC register (feedback form, no augmentation)
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur, input logic din);
    logic fb;
    fb = din ^ cur[CRC_W-1];
    return fb ? ({cur[CRC_W-2:0], 1'b0} ^ CRC_POLY) : {cur[CRC_W-2:0], 1'b0};
  endfunction

  // Number of data bytes carried by a frame
  function automatic logic [3:0] payload_bytes(input logic [3:0] code, input logic remote,
                                               input logic [3:0] cap);
    if (remote) return 4'd0;
    return (code > cap) ? cap : code;
  endfunction

endpackage

// File: rtl/can_bit_destuff.sv
module can_bit_destuff #(
  parameter int RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic rx_bit,
  input  logic restart,
  input  logic active,
  output logic drop,
  output logic err,
  output logic pending
);
  localparam int RW = $clog2(RUN_LIMIT + 1);

  logic          last_q;
  logic [RW-1:0] run_q;
  logic          slot;

  assign slot    = (run_q == RW'(RUN_LIMIT));
  assign pending = slot;
  assign drop    = strobe & active & slot & (rx_bit != last_q);
  assign err     = strobe & active & slot & (rx_bit == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      run_q  <= '0;
    end else if (strobe) begin
      if (restart) begin
        last_q <= rx_bit;
        run_q  <= RW'(1);
      end else if (active) begin
        if (slot || rx_bit != last_q) begin
          last_q <= rx_bit;
          run_q  <= RW'(1);
        end else begin
          run_q <= run_q + RW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/can_crc15_acc.sv
module can_crc15_acc
  import can_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc <= '0;
    else if (clear)    crc <= '0;
    else if (shift_en) crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/can_frame_fsm.sv
module can_frame_fsm
  import can_chk_pkg::*;
#(
  parameter int IDLE_BITS    = 11,
  parameter int INTERMISSION = 3,
  parameter int EOF_BITS     = 7,
  parameter int ID_A_BITS    = 11,
  parameter int ID_B_BITS    = 18,
  parameter int MAX_BYTES    = 8,
  localparam int ID_W        = ID_A_BITS + ID_B_BITS,
  localparam int DATA_W      = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              rx_bit,
  input  logic              ds_drop,
  input  logic              ds_err,
  input  logic              ds_pending,
  input  logic [CRC_W-1:0]  crc_val,
  output logic              ds_restart,
  output logic              ds_active,
  output logic              crc_clear,
  output logic              crc_shift,
  output logic              field_bit,
  output logic              hit_err,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code,
  output logic [ID_W-1:0]   id,
  output logic              ext,
  output logic              rtr,
  output logic [3:0]        dlc,
  output logic [DATA_W-1:0] data
);
  localparam int CW = $clog2((DATA_W > ID_B_BITS) ? DATA_W : ID_B_BITS);
  localparam int IW = $clog2(IDLE_BITS);

  fld_state_e        state;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     data_last;
  logic [IW-1:0]     idle_cnt;
  logic [CRC_W-2:0]  crc_rx_q;
  rx_err_e           hit_code;
  logic              in_stuffed;
  logic              in_crc_span;
  logic [3:0]        dlc_next;
  logic [3:0]        nb_next;

  always_comb begin
    in_stuffed  = 1'b0;
    in_crc_span = 1'b0;
    case (state)
      FS_BASE_ID, FS_BIT12, FS_IDE, FS_EXT_ID, FS_EXT_RTR,
      FS_RES1, FS_RES0, FS_DLC, FS_DATA: begin
        in_stuffed  = 1'b1;
        in_crc_span = 1'b1;
      end
      FS_CRC:  in_stuffed = 1'b1;
      default: ;
    endcase
  end

  assign ds_active  = in_stuffed | ((state == FS_CRC_DELIM) & ds_pending);
  assign ds_restart = (state == FS_IDLE) & ~rx_bit;
  assign crc_clear  = strobe & ds_restart;
  assign field_bit  = strobe & ~ds_drop & ~ds_err;
  assign crc_shift  = field_bit & in_crc_span;
  assign dlc_next   = {dlc[2:0], rx_bit};
  assign nb_next    = payload_bytes(dlc_next, rtr, 4'(MAX_BYTES));

  // Error event of the current bit, priority stuff first
  always_comb begin
    hit_err  = 1'b0;
    hit_code = ERR_NONE;
    if (ds_err) begin
      hit_err  = 1'b1;
      hit_code = ERR_STUFF;
    end else if (field_bit) begin
      case (state)
        FS_CRC:
          if (cnt == CW'(CRC_W - 1) && {crc_rx_q, rx_bit} != crc_val) begin
            hit_err  = 1'b1;
            hit_code = ERR_CRC;
          end
        FS_CRC_DELIM, FS_ACK_DELIM, FS_EOF:
          if (!rx_bit) begin
            hit_err  = 1'b1;
            hit_code = ERR_FORM;
          end
        FS_ACK_SLOT:
          if (rx_bit) begin
            hit_err  = 1'b1;
            hit_code = ERR_ACK;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FS_WAIT_IDLE;
      cnt       <= '0;
      data_last <= '0;
      idle_cnt  <= '0;
      crc_rx_q  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= ERR_NONE;
      id        <= '0;
      ext       <= 1'b0;
      rtr       <= 1'b0;
      dlc       <= '0;
      data      <= '0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= ERR_NONE;
      if (hit_err) begin
        err      <= 1'b1;
        err_code <= hit_code;
        state    <= FS_WAIT_IDLE;
        idle_cnt <= '0;
      end else if (strobe && state == FS_WAIT_IDLE) begin
        if (!rx_bit) begin
          idle_cnt <= '0;
        end else if (idle_cnt == IW'(IDLE_BITS - 1)) begin
          idle_cnt <= '0;
          state    <= FS_IDLE;
        end else begin
          idle_cnt <= idle_cnt + IW'(1);
        end
      end else if (field_bit) begin
        case (state)
          FS_IDLE:
            if (!rx_bit) begin
              state <= FS_BASE_ID;
              cnt   <= '0;
              id    <= '0;
              ext   <= 1'b0;
              rtr   <= 1'b0;
              dlc   <= '0;
              data  <= '0;
            end
          FS_BASE_ID: begin
            id <= {id[ID_W-2:0], rx_bit};
            if (cnt == CW'(ID_A_BITS - 1)) begin
              cnt   <= '0;
              state <= FS_BIT12;
            end else cnt <= cnt + CW'(1);
          end
          FS_BIT12: begin
            rtr   <= rx_bit;
            state <= FS_IDE;
          end
          FS_IDE: begin
            ext   <= rx_bit;
            cnt   <= '0;
            state <= rx_bit ? FS_EXT_ID : FS_RES0;
          end
          FS_EXT_ID: begin
            id <= {id[ID_W-2:0], rx_bit};
            if (cnt == CW'(ID_B_BITS - 1)) begin
              cnt   <= '0;
              state <= FS_EXT_RTR;
            end else cnt <= cnt + CW'(1);
          end
          FS_EXT_RTR: begin
            rtr   <= rx_bit;
            state <= FS_RES1;
          end
          FS_RES1: state <= FS_RES0;
          FS_RES0: begin
            cnt   <= '0;
            state <= FS_DLC;
          end
          FS_DLC: begin
            dlc <= dlc_next;
            if (cnt == CW'(3)) begin
              cnt       <= '0;
              data_last <= CW'({nb_next, 3'b000} - 7'd1);
              state     <= (nb_next == 4'd0) ? FS_CRC : FS_DATA;
            end else cnt <= cnt + CW'(1);
          end
          FS_DATA: begin
            data[{cnt[CW-1:3], ~cnt[2:0]}] <= rx_bit;
            if (cnt == data_last) begin
              cnt   <= '0;
              state <= FS_CRC;
            end else cnt <= cnt + CW'(1);
          end
          FS_CRC: begin
            crc_rx_q <= {crc_rx_q[CRC_W-3:0], rx_bit};
            if (cnt == CW'(CRC_W - 1)) begin
              cnt   <= '0;
              state <= FS_CRC_DELIM;
            end else cnt <= cnt + CW'(1);
          end
          FS_CRC_DELIM: state <= FS_ACK_SLOT;
          FS_ACK_SLOT:  state <= FS_ACK_DELIM;
          FS_ACK_DELIM: begin
            cnt   <= '0;
            state <= FS_EOF;
          end
          FS_EOF:
            if (cnt == CW'(EOF_BITS - 1)) begin
              done     <= 1'b1;
              cnt      <= '0;
              idle_cnt <= IW'(IDLE_BITS - INTERMISSION);
              state    <= FS_WAIT_IDLE;
            end else cnt <= cnt + CW'(1);
          default: state <= FS_WAIT_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/can_rx_frame_checker.sv
module can_rx_frame_checker
  import can_chk_pkg::*;
#(
  parameter int IDLE_BITS    = 11,
  parameter int INTERMISSION = 3,
  parameter int EOF_BITS     = 7,
  parameter int STUFF_RUN    = 5,
  parameter int ID_A_BITS    = 11,
  parameter int ID_B_BITS    = 18,
  parameter int MAX_BYTES    = 8,
  localparam int ID_W        = ID_A_BITS + ID_B_BITS,
  localparam int DATA_W      = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_strobe,
  input  logic              bus_bit,
  output logic              frame_done,
  output logic [ID_W-1:0]   frame_id,
  output logic              frame_ext,
  output logic              frame_rtr,
  output logic [3:0]        frame_dlc,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_err,
  output logic [2:0]        frame_err_code
);
  logic             ds_drop;
  logic             ds_err;
  logic             ds_pending;
  logic             ds_restart;
  logic             ds_active;
  logic             crc_clear;
  logic             crc_shift;
  logic             field_bit;
  logic             hit_err;
  logic [CRC_W-1:0] crc_val;

  can_bit_destuff #(.RUN_LIMIT(STUFF_RUN)) u_destuff (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (bit_strobe),
    .rx_bit  (bus_bit),
    .restart (ds_restart),
    .active  (ds_active),
    .drop    (ds_drop),
    .err     (ds_err),
    .pending (ds_pending)
  );

  can_crc15_acc u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (crc_clear),
    .shift_en (crc_shift),
    .din      (bus_bit),
    .crc      (crc_val)
  );

  can_frame_fsm #(
    .IDLE_BITS    (IDLE_BITS),
    .INTERMISSION (INTERMISSION),
    .EOF_BITS     (EOF_BITS),
    .ID_A_BITS    (ID_A_BITS),
    .ID_B_BITS    (ID_B_BITS),
    .MAX_BYTES    (MAX_BYTES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (bit_strobe),
    .rx_bit     (bus_bit),
    .ds_drop    (ds_drop),
    .ds_err     (ds_err),
    .ds_pending (ds_pending),
    .crc_val    (crc_val),
    .ds_restart (ds_restart),
    .ds_active  (ds_active),
    .crc_clear  (crc_clear),
    .crc_shift  (crc_shift),
    .field_bit  (field_bit),
    .hit_err    (hit_err),
    .done       (frame_done),
    .err        (frame_err),
    .err_code   (frame_err_code),
    .id         (frame_id),
    .ext        (frame_ext),
    .rtr        (frame_rtr),
    .dlc        (frame_dlc),
    .data       (frame_data)
  );

endmodule

// File: rtl/can_rx_frame_checker_sva.sv
module can_rx_frame_checker_sva #(
  parameter int ID_W      = 29,
  parameter int DATA_W    = 64,
  parameter int ID_A_BITS = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_strobe,
  input logic              frame_done,
  input logic              frame_err,
  input logic [2:0]        frame_err_code,
  input logic              frame_ext,
  input logic              frame_rtr,
  input logic [ID_W-1:0]   frame_id,
  input logic [DATA_W-1:0] frame_data,
  input logic              ds_drop,
  input logic              ds_err,
  input logic              crc_shift,
  input logic              hit_err
);
  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9: completion follows a sampled bit
  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(bit_strobe));

  // R10: error is a single-cycle pulse
  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R10: a frame never ends both ways
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_err));

  // R10: every detected error event reaches the port on the next edge
  a_r10_hit_to_port: assert property (@(posedge clk) disable iff (!rst_n)
    hit_err |=> frame_err);

  // R11: code reads zero without an error pulse
  a_r11_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_err |-> frame_err_code == 3'd0);

  // R11: code is one of the four defined values during the pulse
  a_r11_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (frame_err_code >= 3'd1 && frame_err_code <= 3'd4));

  // R3: a stuff violation is reported as code 1
  a_r3_stuff_code: assert property (@(posedge clk) disable iff (!rst_n)
    ds_err |=> (frame_err && frame_err_code == 3'd1));

  // R2: a discarded stuff bit never enters the CRC
  a_r2_drop_not_crc: assert property (@(posedge clk) disable iff (!rst_n)
    ds_drop |-> !crc_shift);

  // R4: a standard identifier leaves the upper bits zero
  a_r4_std_id_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_ext) |-> frame_id[ID_W-1:ID_A_BITS] == '0);

  // R5: a remote frame carries no data
  a_r5_remote_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_rtr) |-> frame_data == '0);

endmodule

bind can_rx_frame_checker can_rx_frame_checker_sva #(
  .ID_W      (ID_W),
  .DATA_W    (DATA_W),
  .ID_A_BITS (ID_A_BITS)
) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .bit_strobe     (bit_strobe),
  .frame_done     (frame_done),
  .frame_err      (frame_err),
  .frame_err_code (frame_err_code),
  .frame_ext      (frame_ext),
  .frame_rtr      (frame_rtr),
  .frame_id       (frame_id),
  .frame_data     (frame_data),
  .ds_drop        (ds_drop),
  .ds_err         (ds_err),
  .crc_shift      (crc_shift),
  .hit_err        (hit_err)
);

// File: tb/tb_can_rx_frame_checker.sv
module tb_can_rx_frame_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_strobe = 1'b0;
  logic        bus_bit = 1'b1;
  logic        frame_done;
  logic [28:0] frame_id;
  logic        frame_ext;
  logic        frame_rtr;
  logic [3:0]  frame_dlc;
  logic [63:0] frame_data;
  logic        frame_err;
  logic [2:0]  frame_err_code;

  always #4 clk = ~clk;

  can_rx_frame_checker dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_strobe     (bit_strobe),
    .bus_bit        (bus_bit),
    .frame_done     (frame_done),
    .frame_id       (frame_id),
    .frame_ext      (frame_ext),
    .frame_rtr      (frame_rtr),
    .frame_dlc      (frame_dlc),
    .frame_data     (frame_data),
    .frame_err      (frame_err),
    .frame_err_code (frame_err_code)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // frame buffers
  bit ubuf [0:255];
  int un;
  bit sbuf [0:383];
  int sn;
  int p_crc_last, p_stuff1, p_crc_del, p_ack, p_ackdel, p_eof;

  // observed events
  int          ev_count;
  int          ev_idx;
  bit          ev_is_done;
  logic [2:0]  ev_code;
  logic [28:0] cap_id;
  logic        cap_ext, cap_rtr;
  logic [3:0]  cap_dlc;
  logic [63:0] cap_data;
  int          bit_idx;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] ref_crc(input int n);
    logic [15:0] r;
    r = 16'h0;
    for (int i = 0; i < n + 15; i++) begin
      r = {r[14:0], (i < n) ? ubuf[i] : 1'b0};
      if (r[15]) r = r ^ 16'hC599;
    end
    return r[14:0];
  endfunction

  function automatic int ref_bytes(input logic [3:0] d, input bit remote);
    if (remote) return 0;
    return (d > 8) ? 8 : int'(d);
  endfunction

  task automatic put_u(input bit v);
    ubuf[un] = v;
    un++;
  endtask

  task automatic put_s(input bit v);
    sbuf[sn] = v;
    sn++;
  endtask

  task automatic build_frame(input bit ext, input logic [28:0] id, input bit rtr,
                             input logic [3:0] dlc, input logic [63:0] data, input bit bad_crc);
    logic [14:0] c;
    int nb, run;
    bit last;
    un = 0;
    put_u(1'b0);
    if (!ext) begin
      for (int i = 10; i >= 0; i--) put_u(id[i]);
      put_u(rtr); put_u(1'b0); put_u(1'b0);
    end else begin
      for (int i = 28; i >= 18; i--) put_u(id[i]);
      put_u(1'b1); put_u(1'b1);
      for (int i = 17; i >= 0; i--) put_u(id[i]);
      put_u(rtr); put_u(1'b0); put_u(1'b0);
    end
    for (int i = 3; i >= 0; i--) put_u(dlc[i]);
    nb = ref_bytes(dlc, rtr);
    for (int k = 0; k < nb; k++)
      for (int b = 7; b >= 0; b--) put_u(data[8*k+b]);
    c = ref_crc(un);
    if (bad_crc) c = c ^ 15'h0400;
    for (int i = 14; i >= 0; i--) put_u(c[i]);
    sn = 0; p_stuff1 = -1; run = 0; last = 1'b1;
    for (int i = 0; i < un; i++) begin
      if (sn > 0 && ubuf[i] == last) run++; else run = 1;
      last = ubuf[i];
      if (i == un - 1) p_crc_last = sn;
      put_s(ubuf[i]);
      if (run == 5) begin
        if (p_stuff1 < 0) p_stuff1 = sn;
        put_s(~last);
        last = ~last;
        run = 1;
      end
    end
    p_crc_del = sn; put_s(1'b1);
    p_ack = sn;     put_s(1'b0);
    p_ackdel = sn;  put_s(1'b1);
    p_eof = sn;
    for (int i = 0; i < 7; i++) put_s(1'b1);
  endtask

  task automatic observe();
    if (frame_done) begin
      ev_count++; ev_idx = bit_idx; ev_is_done = 1'b1; ev_code = 3'd0;
      cap_id = frame_id; cap_ext = frame_ext; cap_rtr = frame_rtr;
      cap_dlc = frame_dlc; cap_data = frame_data;
    end
    if (frame_err) begin
      ev_count++; ev_idx = bit_idx; ev_is_done = 1'b0; ev_code = frame_err_code;
    end
  endtask

  task automatic send_bit(input bit b);
    int gap;
    @(negedge clk);
    bit_strobe = 1'b1;
    bus_bit = b;
    @(negedge clk);
    bit_strobe = 1'b0;
    bus_bit = 1'b1;
    observe();
    gap = $urandom_range(0, 2);
    repeat (gap) begin
      @(negedge clk);
      observe();
    end
    bit_idx++;
  endtask

  task automatic send_recessive(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  // mode: 0 good, 1 crc, 2 stuff, 3 crc delim, 4 ack, 5 ack delim, 6 eof bit
  task automatic run_case(input string tag, input bit ext, input logic [28:0] id, input bit rtr,
                          input logic [3:0] dlc, input logic [63:0] data, input int mode_in,
                          input int eofk, input bit armed, input int gap_after);
    int mode, exp_idx, nb;
    logic [2:0] exp_code;
    logic [28:0] exp_id;
    logic [63:0] exp_data;
    string ctag;
    mode = mode_in;
    build_frame(ext, id, rtr, dlc, data, mode == 1);
    if (mode == 2 && p_stuff1 < 0) mode = 0;
    case (mode)
      1: begin exp_idx = p_crc_last; exp_code = 3'd3; ctag = "R6"; end
      2: begin sbuf[p_stuff1] = ~sbuf[p_stuff1]; exp_idx = p_stuff1; exp_code = 3'd1; ctag = "R3"; end
      3: begin sbuf[p_crc_del] = 1'b0; exp_idx = p_crc_del; exp_code = 3'd2; ctag = "R7"; end
      4: begin sbuf[p_ack] = 1'b1; exp_idx = p_ack; exp_code = 3'd4; ctag = "R8"; end
      5: begin sbuf[p_ackdel] = 1'b0; exp_idx = p_ackdel; exp_code = 3'd2; ctag = "R7"; end
      6: begin sbuf[p_eof + eofk] = 1'b0; exp_idx = p_eof + eofk; exp_code = 3'd2; ctag = "R7"; end
      default: begin exp_idx = sn - 1; exp_code = 3'd0; ctag = "R9"; end
    endcase
    ev_count = 0; ev_idx = -1; bit_idx = 0; ev_is_done = 1'b0; ev_code = 3'd0;
    for (int i = 0; i < sn; i++) send_bit(sbuf[i]);
    send_recessive(gap_after);
    if (!armed) begin
      chk(ev_count == 0, {tag, " R1 frame before idle ignored"}, ev_count, 0);
      return;
    end
    chk(ev_count == 1, {tag, " R10 one result per frame"}, ev_count, 1);
    chk(ev_idx == exp_idx, {tag, " ", ctag, " result bit index"}, ev_idx, exp_idx);
    chk(ev_is_done == (mode == 0), {tag, " R10 result kind"}, ev_is_done, mode == 0);
    chk(ev_code == exp_code, {tag, " ", ctag, " error code"}, ev_code, exp_code);
    if (mode == 0) begin
      exp_id = ext ? id : {18'h0, id[10:0]};
      nb = ref_bytes(dlc, rtr);
      exp_data = '0;
      for (int k = 0; k < nb; k++) exp_data[8*k +: 8] = data[8*k +: 8];
      chk(cap_id == exp_id, {tag, " R4 identifier"}, cap_id, exp_id);
      chk(cap_ext == ext && cap_rtr == rtr, {tag, " R4 format flags"},
          {cap_ext, cap_rtr}, {ext, rtr});
      chk(cap_dlc == dlc, {tag, " R5 raw dlc"}, cap_dlc, dlc);
      chk(cap_data == exp_data, {tag, " R5 data bytes"}, cap_data, exp_data);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (4) @(negedge clk);
    // R11: outputs quiet while and after reset
    chk(frame_done == 1'b0 && frame_err == 1'b0, "R11 reset pulses low", {frame_done, frame_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_err_code == 3'd0 && frame_id == '0 && frame_data == '0, "R11 reset fields zero",
        frame_err_code, 0);

    // R1: only 10 recessive bits -> frame ignored
    send_recessive(10);
    run_case("d_short_idle", 1'b0, 29'h123, 1'b0, 4'd2, 64'hA5C3, 0, 0, 1'b0, 11);

    // R2: long dominant runs force stuff bits, including the SOF
    run_case("d_stuff_std", 1'b0, 29'h000, 1'b0, 4'd1, 64'h00, 0, 0, 1'b1, 3);
    run_case("d_stuff_ones", 1'b1, 29'h1FFFFFFF, 1'b0, 4'd2, 64'hFFFF, 0, 0, 1'b1, 3);
    // R3: violated stuff bit
    run_case("d_stuff_err", 1'b0, 29'h000, 1'b0, 4'd0, 64'h0, 2, 0, 1'b1, 11);
    // R4 / R5: extended full payload, clamp, remote
    run_case("d_ext_full", 1'b1, 29'h0ABCDEF1, 1'b0, 4'd8, 64'h0123456789ABCDEF, 0, 0, 1'b1, 3);
    run_case("d_dlc_clamp", 1'b0, 29'h7FF, 1'b0, 4'd15, 64'hFEDCBA9876543210, 0, 0, 1'b1, 3);
    run_case("d_remote", 1'b1, 29'h1555AAAA, 1'b1, 4'd5, 64'hFFFFFFFFFF, 0, 0, 1'b1, 3);
    // R6 / R7 / R8 error classes
    run_case("d_crc_err", 1'b0, 29'h3C5, 1'b0, 4'd3, 64'h112233, 1, 0, 1'b1, 11);
    run_case("d_crcdel", 1'b0, 29'h3C5, 1'b0, 4'd1, 64'h5A, 3, 0, 1'b1, 11);
    run_case("d_ack_err", 1'b1, 29'h00FF00FF, 1'b0, 4'd2, 64'h8001, 4, 0, 1'b1, 11);
    run_case("d_ackdel", 1'b0, 29'h2A1, 1'b0, 4'd0, 64'h0, 5, 0, 1'b1, 11);
    run_case("d_eof_first", 1'b0, 29'h2A1, 1'b0, 4'd0, 64'h0, 6, 0, 1'b1, 11);
    run_case("d_eof_last", 1'b0, 29'h2A1, 1'b0, 4'd0, 64'h0, 6, 6, 1'b1, 11);
    // R1: intermission of exactly 3 bits between accepted frames
    run_case("d_b2b_a", 1'b0, 29'h101, 1'b0, 4'd1, 64'h77, 0, 0, 1'b1, 3);
    run_case("d_b2b_b", 1'b0, 29'h202, 1'b0, 4'd1, 64'h88, 0, 0, 1'b1, 3);

    // constrained random frames
    for (int n = 0; n < 40; n++) begin
      bit          ext, rtr;
      logic [28:0] id;
      logic [3:0]  dlc;
      logic [63:0] data;
      int          mode;
      ext  = $urandom_range(0, 1);
      rtr  = ($urandom_range(0, 3) == 0);
      id   = 29'($urandom());
      dlc  = 4'($urandom_range(0, 15));
      data = {$urandom(), $urandom()};
      mode = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 6) : 0;
      run_case("rand", ext, id, rtr, dlc, data, mode, $urandom_range(0, 6), 1'b1,
               (mode == 0) ? 3 : 11);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule